// File: doc/BRIEF.md
# Audio Error Concealment and Rate-Based Mute

This block sits after sample expansion in a digital audio receive path. It takes a stream of signed 14-bit audio samples. Each sample arrives with a flag that marks it as corrupted. A flagged sample is never passed on. It is replaced either by the midpoint between the previous output and the following input, or by a copy of the previous output. Choosing the midpoint requires the following sample, so every sample leaves one sample late.

The block also counts flagged samples in consecutive fixed-length windows. At the close of each window it compares the count against a programmable limit. It mutes when the count is above the limit. It unmutes only when four times the count is below the limit; between those two thresholds the mute state is kept. While muted, emitted samples are zero, but the concealment history keeps being updated.

Both edges use valid/ready handshakes. The last accepted sample stays inside the block until a further sample arrives.

Top module: `audio_conceal_mute`

## Requirements
- R1: After reset, out_valid and mute are low, in_ready is high, and the "previous output" used by concealment is 0.
- R2: A sample whose error flag is low is emitted unchanged while unmuted. It is emitted only once the following sample has been accepted, which is a latency of exactly one sample.
- R3: A flagged sample whose successor is not flagged is emitted as floor((previous output + successor) / 2), computed in two's complement.
- R4: A flagged sample whose successor is also flagged is emitted as the previous output value.
- R5: Flagged samples are counted over windows of WIN_LEN accepted samples (128 by default). The mute decision is taken when the last sample of a window is accepted, and the count then restarts from zero. Mute changes at no other time.
- R6: At a window close, mute is set when the window's error count is greater than err_limit.
- R7: At a window close, mute is cleared when four times the count is below err_limit. Otherwise mute keeps its value.
- R8: A sample emitted while mute is high carries the value 0. Concealment still records the unmuted value as the previous output.
- R9: While out_valid is high and out_ready is low, out_sample holds its value, and no sample is lost or duplicated.
- R10: Samples leave in the order they arrived, one output for each accepted input except the last one held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept an input sample |
| in_sample | input | 14 | Signed input sample |
| in_err | input | 1 | Input sample is corrupted |
| err_limit | input | 8 | Error-count limit per window |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_sample | output | 14 | Signed concealed or muted sample |
| mute | output | 1 | Automatic mute status |

## Verification
The stream runs through seven full windows, each with its own error pattern:
- Isolated flags separate the midpoint path from the repeat path, and a flag on the very first sample shows the zero history after reset.
- Runs of consecutive flags show the repeat path.
- Per-window error counts of 22, 4, 1, 8, 9 and 9 place the count above the limit, between the two thresholds, below a quarter of the limit, and exactly at the limit. This tells the set rule, the hold band and the clear rule apart.
- The limit is raised for the final window to show the clear rule with a changed limit.
- The later windows apply periodic backpressure on the output, so holding and ordering are shown with the concealment running.

// File: rtl/acm_pkg.sv
package acm_pkg;

  localparam int unsigned ACM_SMP_W   = 14;
  localparam int unsigned ACM_WIN_LEN = 128;

  typedef enum logic [1:0] {
    FIX_PASS   = 2'd0,
    FIX_INTERP = 2'd1,
    FIX_REPEAT = 2'd2
  } fix_kind_e;

  function automatic fix_kind_e choose_fix(input logic cur_bad, input logic nxt_bad);
    if (!cur_bad)      return FIX_PASS;
    else if (!nxt_bad) return FIX_INTERP;
    else               return FIX_REPEAT;
  endfunction

endpackage

// File: rtl/acm_conceal.sv
module acm_conceal
  import acm_pkg::*;
#(
  parameter int unsigned SMP_W = ACM_SMP_W
) (
  input  logic [SMP_W-1:0] cur_smp,
  input  logic             cur_bad,
  input  logic [SMP_W-1:0] nxt_smp,
  input  logic             nxt_bad,
  input  logic [SMP_W-1:0] prev_smp,
  output logic [SMP_W-1:0] fix_smp,
  output fix_kind_e        fix_kind
);

  // floor of the signed mean: widen by one bit, add, drop the LSB
  function automatic logic [SMP_W-1:0] mean_floor(input logic [SMP_W-1:0] a,
                                                  input logic [SMP_W-1:0] b);
    logic [SMP_W:0] s;
    s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
    return s[SMP_W:1];
  endfunction

  always_comb begin
    fix_kind = choose_fix(cur_bad, nxt_bad);
    unique case (fix_kind)
      FIX_PASS:   fix_smp = cur_smp;
      FIX_INTERP: fix_smp = mean_floor(prev_smp, nxt_smp);
      default:    fix_smp = prev_smp;
    endcase
  end

endmodule

// File: rtl/acm_err_window.sv
module acm_err_window #(
  parameter  int unsigned WIN_LEN = 128,
  localparam int unsigned CNT_W   = $clog2(WIN_LEN + 1),
  localparam int unsigned IDX_W   = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_fire,
  input  logic             smp_bad,
  input  logic [CNT_W-1:0] limit,
  output logic             mute,
  output logic             win_end,
  output logic [CNT_W-1:0] win_errs
);

  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mute_q;

  function automatic logic above_limit(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return c > l;
  endfunction

  function automatic logic below_quarter(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return {c, 2'b00} < {2'b00, l};
  endfunction

  assign win_errs = cnt_q + CNT_W'(smp_bad);
  assign win_end  = smp_fire && (idx_q == IDX_W'(WIN_LEN - 1));
  assign mute     = mute_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      mute_q <= 1'b0;
    end else if (smp_fire) begin
      if (win_end) begin
        idx_q <= '0;
        cnt_q <= '0;
        if (above_limit(win_errs, limit))        mute_q <= 1'b1;
        else if (below_quarter(win_errs, limit)) mute_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        cnt_q <= win_errs;
      end
    end
  end

endmodule

// File: rtl/acm_lookahead.sv
module acm_lookahead
  import acm_pkg::*;
#(
  parameter int unsigned SMP_W = ACM_SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_sample,
  input  logic             in_err,
  input  logic             mute,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SMP_W-1:0] out_sample,
  output logic             in_fire,
  output logic             emit
);

  logic             pend_vld;
  logic [SMP_W-1:0] pend_smp;
  logic             pend_bad;
  logic [SMP_W-1:0] prev_smp;
  logic             out_vld_q;
  logic [SMP_W-1:0] out_smp_q;
  logic [SMP_W-1:0] fix_smp;
  fix_kind_e        fix_kind;
  logic             out_room;

  assign out_room  = !out_vld_q || out_ready;
  assign in_ready  = !pend_vld || out_room;
  assign in_fire   = in_valid && in_ready;
  assign emit      = in_fire && pend_vld;
  assign out_valid = out_vld_q;
  assign out_sample = out_smp_q;

  acm_conceal #(.SMP_W(SMP_W)) conceal_i (
    .cur_smp  (pend_smp),
    .cur_bad  (pend_bad),
    .nxt_smp  (in_sample),
    .nxt_bad  (in_err),
    .prev_smp (prev_smp),
    .fix_smp  (fix_smp),
    .fix_kind (fix_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_smp  <= '0;
      pend_bad  <= 1'b0;
      prev_smp  <= '0;
      out_vld_q <= 1'b0;
      out_smp_q <= '0;
    end else begin
      if (in_fire) begin
        pend_vld <= 1'b1;
        pend_smp <= in_sample;
        pend_bad <= in_err;
      end
      if (emit) begin
        out_vld_q <= 1'b1;
        out_smp_q <= mute ? '0 : fix_smp;
        prev_smp  <= fix_smp;
      end else if (out_ready) begin
        out_vld_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audio_conceal_mute.sv
module audio_conceal_mute
  import acm_pkg::*;
#(
  parameter  int unsigned SMP_W   = ACM_SMP_W,
  parameter  int unsigned WIN_LEN = ACM_WIN_LEN,
  localparam int unsigned CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_sample,
  input  logic             in_err,
  input  logic [CNT_W-1:0] err_limit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SMP_W-1:0] out_sample,
  output logic             mute
);

  // internal events, named for the bound checker
  logic             in_fire;
  logic             emit;
  logic             win_end;
  logic [CNT_W-1:0] win_errs;

  acm_err_window #(.WIN_LEN(WIN_LEN)) win_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_fire (in_fire),
    .smp_bad  (in_err),
    .limit    (err_limit),
    .mute     (mute),
    .win_end  (win_end),
    .win_errs (win_errs)
  );

  acm_lookahead #(.SMP_W(SMP_W)) look_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sample  (in_sample),
    .in_err     (in_err),
    .mute       (mute),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .in_fire    (in_fire),
    .emit       (emit)
  );

endmodule

// File: rtl/acm_checker.sv
module acm_checker #(
  parameter int unsigned SMP_W   = 14,
  parameter int unsigned WIN_LEN = 128,
  parameter int unsigned CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_fire,
  input logic             emit,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SMP_W-1:0] out_sample,
  input logic             mute,
  input logic             win_end,
  input logic [CNT_W-1:0] win_errs,
  input logic [CNT_W-1:0] err_limit
);

  // R2: output appears only after an input is taken
  p_out_after_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_fire));

  // R5: mute moves only at a window close
  p_mute_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mute) |-> $past(win_end));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_errs <= CNT_W'(WIN_LEN));

  // R6: rising mute follows a window above the limit
  p_mute_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> ($past(win_errs) > $past(err_limit)));

  // R7: falling mute follows a window below a quarter of the limit
  p_mute_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> ({$past(win_errs), 2'b00} < {2'b00, $past(err_limit)}));

  // R8: samples produced while muted are zero
  p_mute_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && mute) |=> (out_sample == '0));

  // R9: stalled output is held
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

endmodule

bind audio_conceal_mute acm_checker #(
  .SMP_W(SMP_W), .WIN_LEN(WIN_LEN), .CNT_W(CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_fire    (in_fire),
  .emit       (emit),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample),
  .mute       (mute),
  .win_end    (win_end),
  .win_errs   (win_errs),
  .err_limit  (err_limit)
);

// File: tb/audio_conceal_mute_tb_top.sv
module audio_conceal_mute_tb_top;

  localparam int SMP_W   = 14;
  localparam int WIN_LEN = 128;
  localparam int CNT_W   = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [SMP_W-1:0] in_sample = '0;
  logic             in_err = 1'b0;
  logic [CNT_W-1:0] err_limit = 8'd8;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [SMP_W-1:0] out_sample;
  logic             mute;

  always #5 clk = ~clk;

  audio_conceal_mute dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_err(in_err), .err_limit(err_limit),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .mute(mute)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  // reference state
  int m_prev = 0;
  bit m_have = 1'b0;
  int m_psmp = 0;
  bit m_perr = 1'b0;
  bit m_mute = 1'b0;
  int m_cnt  = 0;
  int m_idx  = 0;

  bit stall_mode = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_mode ? (cyc % 3 != 1) : 1'b1;
  end

  function automatic int as_int(input logic [SMP_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int half_down(input int s);
    if (s < 0 && (s % 2 != 0)) return (s - 1) / 2;
    return s / 2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic push(input int v, input bit e);
    if (m_have) begin
      int fx;
      if (!m_perr)  fx = m_psmp;            // R2
      else if (!e)  fx = half_down(m_prev + v); // R3
      else          fx = m_prev;            // R4
      m_prev = fx;
      exp_q.push_back(m_mute ? 0 : fx);     // R8
      tag_q.push_back(m_mute ? "R8 muted" : (!m_perr ? "R2 pass" : (!e ? "R3 interp" : "R4 repeat")));
    end
    m_have = 1'b1;
    m_psmp = v;
    m_perr = e;
    m_cnt += int'(e);
    m_idx++;
    if (m_idx == WIN_LEN) begin             // R5 R6 R7
      if (m_cnt > int'(err_limit))          m_mute = 1'b1;
      else if (4 * m_cnt < int'(err_limit)) m_mute = 1'b0;
      m_cnt = 0;
      m_idx = 0;
    end
    in_valid  = 1'b1;
    in_sample = v[SMP_W-1:0];
    in_err    = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_err   = 1'b0;
  endtask

  function automatic bit err_of(input int w, input int j);
    case (w)
      0: return (j == 0 || j == 10 || j == 20 || j == 21 || j == 22 || j == 50 || j == 51);
      1: return (j % 6 == 0);
      2: return (j % 32 == 5);
      3: return (j == 64);
      4: return (j % 16 == 1);
      default: return (j % 14 == 2);
    endcase
  endfunction

  // output monitor, sampled away from the active edge
  logic [SMP_W-1:0] held = '0;
  bit               was_stalled = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (was_stalled)
        check(out_valid && out_sample == held, "R9 stall hold", as_int(out_sample), as_int(held));
      was_stalled = out_valid && !out_ready;
      held = out_sample;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 extra output", as_int(out_sample), 0);
        end else begin
          int    ev;
          string tg;
          ev = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(as_int(out_sample) == ev, tg, as_int(out_sample), ev);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(mute == 1'b0, "R1 mute", int'(mute), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 7; w++) begin
      err_limit  = (w == 6) ? 8'd40 : 8'd8;
      stall_mode = (w >= 4);
      for (int j = 0; j < WIN_LEN; j++) begin
        int v;
        v = ((w * WIN_LEN + j) * 733 + 91) % 16384 - 8192;
        push(v, err_of(w, j));
      end
      check(mute == m_mute, "R5 R6 R7 window mute", int'(mute), int'(m_mute));
    end
    stall_mode = 1'b0;
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R10 outputs drained", exp_q.size(), 0);
    check(out_valid == 1'b0, "R2 last sample held back", int'(out_valid), 0);
    finish_run();
  end

endmodule